// File: doc/BRIEF.md
# Single-Channel DMA Transfer Engine

This block is the data-moving core of one DMA channel. A configuration strobe loads a control word, a source address, a destination address and a cycle count. When the control word enables the channel, the engine runs a fixed number of transfer cycles. Each cycle is one unit in single mode and four units in burst mode. For every unit it first reads from the source and then writes the returned data to the destination. After each unit both addresses move by a signed step chosen per side. Each side is independently routed to the system bus or the peripheral bus through a select bit that comes with every request.

A transfer cycle can wait on a peripheral request line. The source and destination each name a line from 1 to 15, and line 0 means the side runs without pacing. When a paced cycle completes, the engine pulses the grant for each named line. The remaining cycle count is visible at all times and counts down as cycles complete. The engine reports the end of a transfer or a bus error with one-clock pulses. Software can clear the enable bit during a transfer to stop it at the next unit boundary.

The control is a four-state machine:
- `ST_IDLE` waits for a load.
- `ST_PACE` waits for the handshake lines at the start of each cycle.
- `ST_READ` holds a source read until it is acknowledged.
- `ST_WRITE` holds a destination write until it is acknowledged.

The transitions are:
- IDLE→PACE on an enabling load with a nonzero count.
- PACE→READ when the required lines are high.
- PACE→IDLE on abort.
- READ→WRITE on a clean read acknowledge.
- READ→IDLE on a read error.
- WRITE→READ on the next unit within a cycle.
- WRITE→PACE at the end of a cycle that is not the last.
- WRITE→IDLE on finish, on abort or on a write error.

Top module: `dma_chan_engine`

## Requirements
- R1: After a load with enable (bit 0) set and a nonzero count, each unit issues a read of the source address and then a write of the returned data to the destination address. The write request starts only after the read acknowledge. `m_sys` is 1 for the system bus, taken from control bit 6 for reads and bit 7 for writes.
- R2: Step codes sit in control bits 10:8 (source) and 14:12 (destination). The codes are 000 hold, 001 +1, 010 +2, 011 +4, 100 hold, 101 -1, 110 -2 and 111 -4. In burst mode (control bit 3) every magnitude is multiplied by four. Both addresses advance after every completed unit, wrapping at the address width.
- R3: In burst mode one cycle is four units. Otherwise it is one unit. The count does not change between units of a cycle.
- R4: The width field in control bits 21:20 drives `m_size`: 00 gives 2 (word), 01 gives 1 (halfword), 10 gives 0 (byte), and 11 is treated as word.
- R5: `remain` takes the cycle count on a load in idle and decreases by exactly one each time a cycle completes.
- R6: When the last cycle completes, `done` pulses for one clock, `busy` clears and no further request is issued.
- R7: A load with enable set and a count of zero pulses `done` on the following clock without any bus request.
- R8: The source line sits in control bits 27:24 and the destination line in bits 19:16. For a nonzero line, no request of a cycle is issued until `hs_req` at that line is high. At the end of each cycle, `hs_grant` pulses for one clock on each nonzero line. Line 0 needs no request and gets no grant.
- R9: An acknowledge with `m_err` pulses `error`, clears `busy`, issues no write for that unit and leaves `remain` unchanged.
- R10: A load with enable clear while busy lets the current unit finish and then stops without `done`. The address and count fields of that load are ignored.
- R11: While `m_req` is high and not acknowledged, the request, `m_addr` and `m_write` stay unchanged.
- R12: After reset the engine is idle, with no request, no grant, no pulses and `remain` at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_load | input | 1 | Load strobe for the four configuration values |
| cfg_ctrl | input | 32 | Control word |
| cfg_src | input | ADDR_W | Source start address |
| cfg_dst | input | ADDR_W | Destination start address |
| cfg_cycles | input | CNT_W | Number of transfer cycles |
| m_req | output | 1 | Bus access request |
| m_write | output | 1 | 1 for write, 0 for read |
| m_sys | output | 1 | 1 routes the access to the system bus, 0 to the peripheral bus |
| m_addr | output | ADDR_W | Access address |
| m_size | output | 2 | log2 of access bytes |
| m_wdata | output | DATA_W | Write data |
| m_rdata | input | DATA_W | Read data, valid with acknowledge |
| m_ack | input | 1 | Access complete |
| m_err | input | 1 | Access failed, valid with acknowledge |
| hs_req | input | 16 | Peripheral request lines |
| hs_grant | output | 16 | Peripheral grant pulses |
| remain | output | CNT_W | Remaining cycle count |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Finish pulse |
| error | output | 1 | Bus error pulse |

## Verification
The bench builds the engine with a 16-bit address, 32-bit data and a 24-bit count. The narrow address lets a decrementing source started just above zero wrap below it within a few units, so modular stepping is checked at a real boundary. Acknowledge latencies of zero, one and two clocks exercise back-to-back units as well as stalled requests. Short counts put the finish, abort and error paths within a handful of cycles.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

    localparam int CTRL_W       = 32;
    localparam int LINE_W       = 4;
    localparam int HS_LINES     = 1 << LINE_W;
    localparam int BURST_LEN    = 4;
    localparam int UNIT_W       = $clog2(BURST_LEN);

    localparam int BIT_EN       = 0;
    localparam int BIT_BURST    = 3;
    localparam int BIT_SRC_SYS  = 6;
    localparam int BIT_DST_SYS  = 7;
    localparam int SRC_STEP_LSB = 8;
    localparam int DST_STEP_LSB = 12;
    localparam int DST_LINE_LSB = 16;
    localparam int WIDTH_LSB    = 20;
    localparam int SRC_LINE_LSB = 24;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PACE  = 2'd1,
        ST_READ  = 2'd2,
        ST_WRITE = 2'd3
    } chan_state_e;

    typedef struct packed {
        logic              burst;
        logic              src_sys;
        logic              dst_sys;
        logic [2:0]        src_step;
        logic [2:0]        dst_step;
        logic [LINE_W-1:0] src_line;
        logic [LINE_W-1:0] dst_line;
        logic [1:0]        size;
    } chan_cfg_t;

    function automatic chan_cfg_t unpack_ctrl(input logic [CTRL_W-1:0] w);
        chan_cfg_t c;
        c.burst    = w[BIT_BURST];
        c.src_sys  = w[BIT_SRC_SYS];
        c.dst_sys  = w[BIT_DST_SYS];
        c.src_step = w[SRC_STEP_LSB +: 3];
        c.dst_step = w[DST_STEP_LSB +: 3];
        c.src_line = w[SRC_LINE_LSB +: LINE_W];
        c.dst_line = w[DST_LINE_LSB +: LINE_W];
        unique case (w[WIDTH_LSB +: 2])
            2'b01:   c.size = 2'd1;
            2'b10:   c.size = 2'd0;
            default: c.size = 2'd2;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/dma_addr_walker.sv
module dma_addr_walker #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic [2:0]        step_code,
    input  logic              burst,
    input  logic              advance,
    output logic [ADDR_W-1:0] addr
);
    localparam int MAG_W = 5;

    logic [MAG_W-1:0]  mag;
    logic [ADDR_W-1:0] mag_ext;

    always_comb begin
        unique case (step_code[1:0])
            2'd1:    mag = MAG_W'(1);
            2'd2:    mag = MAG_W'(2);
            2'd3:    mag = MAG_W'(4);
            default: mag = '0;
        endcase
        if (burst) begin
            mag = mag << 2;
        end
        mag_ext = ADDR_W'(mag);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr <= '0;
        end else if (load) begin
            addr <= load_addr;
        end else if (advance) begin
            addr <= step_code[2] ? addr - mag_ext : addr + mag_ext;
        end
    end

endmodule

// File: rtl/dma_pace_gate.sv
module dma_pace_gate #(
    parameter int LINE_W = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [(1<<LINE_W)-1:0]   hs_req,
    input  logic [LINE_W-1:0]        src_line,
    input  logic [LINE_W-1:0]        dst_line,
    input  logic                     fire,
    output logic                     ready,
    output logic [(1<<LINE_W)-1:0]   grant
);
    localparam int LINES = 1 << LINE_W;

    logic [LINES-1:0] hit;

    assign ready = ((src_line == '0) || hs_req[src_line]) &&
                   ((dst_line == '0) || hs_req[dst_line]);

    assign hit[0] = 1'b0;
    for (genvar i = 1; i < LINES; i++) begin : g_line
        assign hit[i] = (src_line == LINE_W'(i)) || (dst_line == LINE_W'(i));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            grant <= '0;
        end else begin
            grant <= fire ? hit : '0;
        end
    end

endmodule

// File: rtl/dma_chan_engine.sv
module dma_chan_engine
    import dma_chan_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 24
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_load,
    input  logic [CTRL_W-1:0]   cfg_ctrl,
    input  logic [ADDR_W-1:0]   cfg_src,
    input  logic [ADDR_W-1:0]   cfg_dst,
    input  logic [CNT_W-1:0]    cfg_cycles,
    output logic                m_req,
    output logic                m_write,
    output logic                m_sys,
    output logic [ADDR_W-1:0]   m_addr,
    output logic [1:0]          m_size,
    output logic [DATA_W-1:0]   m_wdata,
    input  logic [DATA_W-1:0]   m_rdata,
    input  logic                m_ack,
    input  logic                m_err,
    input  logic [HS_LINES-1:0] hs_req,
    output logic [HS_LINES-1:0] hs_grant,
    output logic [CNT_W-1:0]    remain,
    output logic                busy,
    output logic                done,
    output logic                error
);
    chan_state_e state, state_n;
    chan_cfg_t   cfg, cfg_in;

    logic [CNT_W-1:0]  remain_q;
    logic [UNIT_W-1:0] unit_q;
    logic              abort_q;
    logic [DATA_W-1:0] rdata_q;
    logic              done_q, error_q;
    logic [ADDR_W-1:0] src_addr, dst_addr;
    logic              pace_ok;

    logic idle_load, start_ev, zero_ev, abort_ev;
    logic rd_ok, rd_bad, wr_ok, wr_bad;
    logic unit_last, cyc_end, fin, stop_now;
    logic unused_ctrl_bits;

    assign cfg_in = unpack_ctrl(cfg_ctrl);
    assign unused_ctrl_bits = ^{cfg_ctrl[31:28], cfg_ctrl[23:22], cfg_ctrl[15],
                                cfg_ctrl[11], cfg_ctrl[5:4], cfg_ctrl[2:1]};

    // event decode
    always_comb begin
        idle_load = cfg_load && (state == ST_IDLE);
        start_ev  = idle_load && cfg_ctrl[BIT_EN] && (cfg_cycles != '0);
        zero_ev   = idle_load && cfg_ctrl[BIT_EN] && (cfg_cycles == '0);
        abort_ev  = cfg_load && (state != ST_IDLE) && !cfg_ctrl[BIT_EN];
        rd_ok     = (state == ST_READ)  && m_ack && !m_err;
        rd_bad    = (state == ST_READ)  && m_ack &&  m_err;
        wr_ok     = (state == ST_WRITE) && m_ack && !m_err;
        wr_bad    = (state == ST_WRITE) && m_ack &&  m_err;
        unit_last = cfg.burst ? (unit_q == UNIT_W'(BURST_LEN - 1)) : 1'b1;
        cyc_end   = wr_ok && unit_last;
        fin       = cyc_end && (remain_q == CNT_W'(1));
        stop_now  = wr_ok && !fin && (abort_q || abort_ev);
    end

    // next state
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE: begin
                if (start_ev) state_n = ST_PACE;
            end
            ST_PACE: begin
                if (abort_ev || abort_q) state_n = ST_IDLE;
                else if (pace_ok)        state_n = ST_READ;
            end
            ST_READ: begin
                if (rd_bad)     state_n = ST_IDLE;
                else if (rd_ok) state_n = ST_WRITE;
            end
            ST_WRITE: begin
                if (wr_bad || fin || stop_now) state_n = ST_IDLE;
                else if (cyc_end)              state_n = ST_PACE;
                else if (wr_ok)                state_n = ST_READ;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg      <= '0;
            remain_q <= '0;
            unit_q   <= '0;
            abort_q  <= 1'b0;
            rdata_q  <= '0;
            done_q   <= 1'b0;
            error_q  <= 1'b0;
        end else begin
            done_q  <= fin || zero_ev;
            error_q <= rd_bad || wr_bad;
            if (idle_load) begin
                cfg      <= cfg_in;
                remain_q <= cfg_cycles;
            end else if (cyc_end) begin
                remain_q <= remain_q - 1'b1;
            end
            if (idle_load)  unit_q <= '0;
            else if (wr_ok) unit_q <= unit_last ? '0 : unit_q + 1'b1;
            if (state_n == ST_IDLE) abort_q <= 1'b0;
            else if (abort_ev)      abort_q <= 1'b1;
            if (rd_ok) rdata_q <= m_rdata;
        end
    end

    // outputs
    always_comb begin
        m_req   = (state == ST_READ) || (state == ST_WRITE);
        m_write = (state == ST_WRITE);
        m_sys   = m_write ? cfg.dst_sys : cfg.src_sys;
        m_addr  = m_write ? dst_addr : src_addr;
        m_size  = cfg.size;
        m_wdata = rdata_q;
        remain  = remain_q;
        busy    = (state != ST_IDLE);
        done    = done_q;
        error   = error_q;
    end

    dma_addr_walker #(.ADDR_W(ADDR_W)) u_src_walk (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (idle_load),
        .load_addr (cfg_src),
        .step_code (cfg.src_step),
        .burst     (cfg.burst),
        .advance   (wr_ok),
        .addr      (src_addr)
    );

    dma_addr_walker #(.ADDR_W(ADDR_W)) u_dst_walk (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (idle_load),
        .load_addr (cfg_dst),
        .step_code (cfg.dst_step),
        .burst     (cfg.burst),
        .advance   (wr_ok),
        .addr      (dst_addr)
    );

    dma_pace_gate #(.LINE_W(LINE_W)) u_pace (
        .clk      (clk),
        .rst_n    (rst_n),
        .hs_req   (hs_req),
        .src_line (cfg.src_line),
        .dst_line (cfg.dst_line),
        .fire     (cyc_end),
        .ready    (pace_ok),
        .grant    (hs_grant)
    );

    assert_write_after_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (m_req && m_write && !$past(m_req && m_write)) |->
            $past(m_req && m_ack && !m_write && !m_err));

    assert_count_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(cfg_load) && (remain != $past(remain))) |->
            (remain == $past(remain) - 1'b1));

    assert_done_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !m_req));

    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_zero_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_load && !busy && cfg_ctrl[BIT_EN] && (cfg_cycles == '0)) |=>
            (done && !busy));

    assert_grant_at_cycle_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (|hs_grant) |-> $past(m_req && m_write && m_ack && !m_err));

    assert_err_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (m_req && m_ack && m_err) |=> (!m_req && !busy && error));

    assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (m_req && !m_ack) |=> (m_req && $stable(m_addr) && $stable(m_write)));

endmodule

// File: tb/test_dma_chan_engine.sv
module test_dma_chan_engine;
    localparam int AW = 16;
    localparam int DW = 32;
    localparam int CW = 24;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic          cfg_load = 1'b0;
    logic [31:0]   cfg_ctrl = '0;
    logic [AW-1:0] cfg_src = '0;
    logic [AW-1:0] cfg_dst = '0;
    logic [CW-1:0] cfg_cycles = '0;
    logic          m_req, m_write, m_sys;
    logic [AW-1:0] m_addr;
    logic [1:0]    m_size;
    logic [DW-1:0] m_wdata;
    logic [DW-1:0] m_rdata = '0;
    logic          m_ack = 1'b0;
    logic          m_err = 1'b0;
    logic [15:0]   hs_req = '1;
    logic [15:0]   hs_grant;
    logic [CW-1:0] remain;
    logic          busy, done, error;

    int n_chk = 0;
    int n_err = 0;
    int lat = 0;

    dma_chan_engine #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(CW)) i_dma_chan_engine (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_ctrl(cfg_ctrl),
        .cfg_src(cfg_src), .cfg_dst(cfg_dst), .cfg_cycles(cfg_cycles),
        .m_req(m_req), .m_write(m_write), .m_sys(m_sys), .m_addr(m_addr),
        .m_size(m_size), .m_wdata(m_wdata), .m_rdata(m_rdata), .m_ack(m_ack),
        .m_err(m_err), .hs_req(hs_req), .hs_grant(hs_grant), .remain(remain),
        .busy(busy), .done(done), .error(error)
    );

    task automatic chk_eq(input string tag, input string what, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] rdval(input logic [AW-1:0] a);
        return {a ^ 16'h5A3C, ~a};
    endfunction

    function automatic int step_amt(input logic [2:0] code, input bit b);
        int m;
        case (code[1:0])
            2'd1:    m = 1;
            2'd2:    m = 2;
            2'd3:    m = 4;
            default: m = 0;
        endcase
        if (b) m = m * 4;
        return code[2] ? -m : m;
    endfunction

    function automatic logic [1:0] size_of(input logic [1:0] w);
        if (w == 2'b01) return 2'd1;
        if (w == 2'b10) return 2'd0;
        return 2'd2;
    endfunction

    task automatic step();
        @(negedge clk);
        cfg_load = 1'b0;
    endtask

    task automatic serve(input bit wr, input logic [AW-1:0] ea, input bit esys,
                         input logic [1:0] esz, input logic [DW-1:0] ewd, input bit give_err);
        int w = 0;
        while (!m_req && w < 200) begin
            step();
            w++;
        end
        for (int i = 0; i < lat; i++) begin
            chk_eq("R11", "request held while unacknowledged", m_req, 1);
            step();
        end
        chk_eq("R1", "request present", m_req, 1);
        chk_eq("R1", "write flag", m_write, wr);
        chk_eq("R2", "address", m_addr, ea);
        chk_eq("R1", "bus select", m_sys, esys);
        chk_eq("R4", "access size", m_size, esz);
        if (wr) chk_eq("R1", "write data", m_wdata, ewd);
        m_rdata = rdval(ea);
        m_ack = 1'b1;
        m_err = give_err;
        step();
        m_ack = 1'b0;
        m_err = 1'b0;
    endtask

    task automatic run_xfer(input logic [31:0] ctrl, input logic [AW-1:0] src, input logic [AW-1:0] dst,
                            input int ncyc, input int hold, input int err_unit, input int abort_unit);
        bit b = ctrl[3];
        int units = ctrl[3] ? 4 : 1;
        logic [AW-1:0] s = src;
        logic [AW-1:0] d = dst;
        int u = 0;
        int ss = step_amt(ctrl[10:8], ctrl[3]);
        int ds = step_amt(ctrl[14:12], ctrl[3]);
        logic [3:0] sl = ctrl[27:24];
        logic [3:0] dl = ctrl[19:16];
        logic [15:0] gmask = '0;
        logic [1:0] esz = size_of(ctrl[21:20]);
        bit last;
        if (b) units = 4;
        if (sl != 0) gmask[sl] = 1'b1;
        if (dl != 0) gmask[dl] = 1'b1;
        if (hold > 0) hs_req = '0;
        cfg_ctrl = ctrl;
        cfg_src = src;
        cfg_dst = dst;
        cfg_cycles = CW'(ncyc);
        cfg_load = 1'b1;
        step();
        chk_eq("R5", "remaining after load", remain, ncyc);
        for (int c = 0; c < ncyc; c++) begin
            if (hold > 0) begin
                hs_req = '0;
                for (int i = 0; i < hold; i++) begin
                    chk_eq("R8", "no request while line low", m_req, 0);
                    step();
                end
                hs_req = '1;
            end
            for (int k = 0; k < units; k++) begin
                serve(1'b0, s, ctrl[6], esz, '0, u == err_unit);
                if (u == err_unit) begin
                    chk_eq("R9", "error pulse", error, 1);
                    chk_eq("R9", "busy after error", busy, 0);
                    chk_eq("R9", "no write after error", m_req, 0);
                    chk_eq("R9", "remaining unchanged", remain, ncyc - c);
                    step();
                    chk_eq("R9", "still no request", m_req, 0);
                    chk_eq("R9", "no finish after error", done, 0);
                    hs_req = '1;
                    return;
                end
                if (u == abort_unit) begin
                    cfg_load = 1'b1;
                    cfg_ctrl = 32'h0;
                    cfg_src = '1;
                    cfg_dst = '1;
                    cfg_cycles = '1;
                end
                serve(1'b1, d, ctrl[7], esz, rdval(s), 1'b0);
                s = s + AW'(ss);
                d = d + AW'(ds);
                last = (k == units - 1);
                chk_eq("R8", "grant lines", hs_grant, last ? gmask : 16'h0);
                if (last) chk_eq("R5", "remaining after cycle", remain, ncyc - c - 1);
                else      chk_eq("R3", "remaining within burst", remain, ncyc - c);
                if (u == abort_unit) begin
                    chk_eq("R10", "busy after abort", busy, 0);
                    chk_eq("R10", "count not reloaded", remain, last ? ncyc - c - 1 : ncyc - c);
                    for (int i = 0; i < 3; i++) begin
                        chk_eq("R10", "no request after abort", m_req, 0);
                        chk_eq("R10", "no finish after abort", done, 0);
                        step();
                    end
                    return;
                end
                if (last && c == ncyc - 1) begin
                    chk_eq("R6", "finish pulse", done, 1);
                    chk_eq("R6", "busy at finish", busy, 0);
                    step();
                    chk_eq("R6", "finish lasts one clock", done, 0);
                    chk_eq("R6", "no request after finish", m_req, 0);
                end else begin
                    chk_eq("R6", "no early finish", done, 0);
                end
                u++;
            end
        end
    endtask

    initial begin
        for (int i = 0; i < 100000; i++) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL R12 watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step();
        chk_eq("R12", "request after reset", m_req, 0);
        chk_eq("R12", "busy after reset", busy, 0);
        chk_eq("R12", "remaining after reset", remain, 0);
        chk_eq("R12", "finish after reset", done, 0);
        chk_eq("R12", "error after reset", error, 0);
        chk_eq("R12", "grant after reset", hs_grant, 0);

        // single word units, source +4 on system bus, destination held
        lat = 0;
        run_xfer(32'h0000_0341, 16'h1000, 16'h2000, 3, 0, -1, -1);
        // burst halfword, source +1x4, destination -2x4 on system bus
        lat = 2;
        run_xfer(32'h0010_6189, 16'h0100, 16'h0800, 2, 0, -1, -1);
        // byte units, source -4 wrapping below zero, destination +2
        lat = 1;
        run_xfer(32'h0020_2701, 16'h0004, 16'h0300, 4, 0, -1, -1);
        // burst with code 100 hold and width 11, paced on lines 3 and 9
        lat = 0;
        run_xfer(32'h0339_4549, 16'h0400, 16'h0A00, 2, 3, -1, -1);
        // destination paced on line 15 only
        run_xfer(32'h000F_1201, 16'h0040, 16'h0080, 2, 2, -1, -1);

        // R7: enabling load with a zero count
        cfg_ctrl = 32'h0000_0341;
        cfg_cycles = '0;
        cfg_load = 1'b1;
        step();
        chk_eq("R7", "finish on zero count", done, 1);
        chk_eq("R7", "no request on zero count", m_req, 0);
        chk_eq("R7", "not busy on zero count", busy, 0);
        step();
        chk_eq("R7", "single finish pulse", done, 0);
        chk_eq("R7", "still no request", m_req, 0);

        // R9: read error on the third unit
        run_xfer(32'h0000_0341, 16'h1000, 16'h2000, 4, 0, 2, -1);
        // R10: abort after the second unit's read
        lat = 1;
        run_xfer(32'h0000_1301, 16'h3000, 16'h5000, 5, 0, -1, 1);
        // R8: free-running with every request line low
        lat = 0;
        hs_req = '0;
        run_xfer(32'h0000_0341, 16'h0600, 16'h0700, 2, 0, -1, -1);
        hs_req = '1;

        step();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule